// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds wall-clock time as eight BCD bytes: seconds, minutes, hours, date, month, year, day of week and a century byte. A single-cycle 1 Hz enable pulse advances the time. Each carry moves into the next field, from seconds up to the century. The hour byte runs in 24-hour form or in 12-hour form with a PM flag. Month length and leap years decide when the date rolls over.

A host never reads or writes the live counters directly. A read strobe copies all eight bytes into a snapshot, and the host reads bytes from that snapshot while the counters keep running. For a write, the host loads a stage buffer, writes individual bytes into it, and then either commits or aborts the transfer. A commit replaces only the bytes written since the last load. The reset state stands for total power loss: a fail flag is raised and the counters stay frozen until the first commit that carries at least one byte.

Top module: `bcd_cal_timer`

## Requirements
- R1: After reset, fail_o is 1 and the bytes read as second 00h, minute 00h, hour 80h, date 01h, month 01h, year 00h, day of week 00h, century 20h. The byte addresses are 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 century.
- R2: While fail_o is 1, tick_i leaves the time unchanged. A commit carrying at least one written byte clears fail_o and counting starts. A commit with no written bytes leaves both the flag and the time as they are.
- R3: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R4: With hour bit 7 = 1, the hour counts 00 to 23 in BCD, then wraps to 00 and advances the date.
- R5: With hour bit 7 = 0, bits 4:0 hold the hour 01 to 12 in BCD and bit 5 = 1 marks PM. The sequence runs 11 to 12 with PM toggled, then 12 to 01 with PM kept. The date advances only when 11 PM becomes 12 AM.
- R6: The date rolls to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 29 or 28 in month 02. February has 29 days when the year is divisible by 4, and year 00 counts as divisible.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and advances the century. The century only moves from 19h to 20h; at 20h it stays 20h.
- R8: The day of week advances together with the date and cycles 0 to 6, then back to 0.
- R9: snap_i copies all bytes into the snapshot in the next cycle, and rd_data_o shows the snapshot byte at rd_addr_i while counting continues. A snapshot taken in the same cycle as tick_i holds the value from before the increment.
- R10: stage_load_i copies the live time into the stage buffer and clears its written-byte mask. wr_en_i replaces one stage byte and marks it as written. commit_i moves only the marked bytes into the counters; the other bytes keep counting undisturbed.
- R11: abort_i discards the written-byte mask, so a later commit changes nothing. When abort_i and commit_i arrive in the same cycle, the abort wins.
- R12: A tick in the same cycle as an effective commit is dropped. The committed value advances on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (total power loss) |
| tick_i | input | 1 | One-cycle 1 Hz advance enable |
| snap_i | input | 1 | Copy the live time into the snapshot |
| rd_addr_i | input | 3 | Snapshot byte select |
| rd_data_o | output | 8 | Selected snapshot byte |
| stage_load_i | input | 1 | Load the live time into the stage buffer and clear the mask |
| wr_en_i | input | 1 | Write one stage byte |
| wr_addr_i | input | 3 | Stage byte select |
| wr_data_i | input | 8 | Stage byte data |
| commit_i | input | 1 | Move the written stage bytes into the counters |
| abort_i | input | 1 | Discard the staged writes |
| fail_o | output | 1 | Power-loss flag; counting is held while set |

## Verification
Every strobe is a single registered step. The counters take a tick or a commit at the next clock edge, and the snapshot takes snap_i at the next edge. rd_data_o follows rd_addr_i combinationally from the snapshot, and fail_o changes one edge after an effective commit. The bench therefore drives each strobe for one cycle just after a rising edge and releases it after the following edge. It then places the read address and queues the expected byte, and the monitor compares at the falling edge, half a cycle after the result is due. Same-edge cases, such as snapshot with tick and commit with tick, are driven together in one cycle so that the order of updates is what the checks see.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NBYTES = 8;
  localparam int AW     = $clog2(NBYTES);

  localparam int IDX_SEC = 0;
  localparam int IDX_MIN = 1;
  localparam int IDX_HR  = 2;
  localparam int IDX_DT  = 3;
  localparam int IDX_MO  = 4;
  localparam int IDX_YR  = 5;
  localparam int IDX_DOW = 6;
  localparam int IDX_CEN = 7;

  typedef logic [NBYTES-1:0][7:0] cal_t;

  // cen, dow, yr, mo, dt, hr, min, sec
  localparam cal_t CAL_RESET = {8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 in BCD: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] y);
    case (mo)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_t cur_i,
  output cal_t nxt_o
);
  logic       c_sec, c_min, c_hr, c_dt, c_mo, c_yr;
  logic [7:0] t;
  logic       pm;

  always_comb begin
    nxt_o = cur_i;
    c_sec = 1'b0; c_min = 1'b0; c_hr = 1'b0;
    c_dt  = 1'b0; c_mo  = 1'b0; c_yr = 1'b0;
    t     = '0;
    pm    = cur_i[IDX_HR][5];

    if (cur_i[IDX_SEC] >= 8'h59) begin
      nxt_o[IDX_SEC] = 8'h00; c_sec = 1'b1;
    end else nxt_o[IDX_SEC] = bcd_inc(cur_i[IDX_SEC]);

    if (c_sec) begin
      if (cur_i[IDX_MIN] >= 8'h59) begin
        nxt_o[IDX_MIN] = 8'h00; c_min = 1'b1;
      end else nxt_o[IDX_MIN] = bcd_inc(cur_i[IDX_MIN]);
    end

    if (c_min) begin
      if (cur_i[IDX_HR][7]) begin
        if (cur_i[IDX_HR][5:0] >= 6'h23) begin
          nxt_o[IDX_HR] = 8'h80; c_hr = 1'b1;
        end else begin
          t = bcd_inc({2'b00, cur_i[IDX_HR][5:0]});
          nxt_o[IDX_HR] = {2'b10, t[5:0]};
        end
      end else begin
        if (cur_i[IDX_HR][4:0] == 5'h11) begin
          nxt_o[IDX_HR] = {2'b00, ~pm, 5'h12};
          c_hr = pm;  // 11 PM -> 12 AM starts a new day
        end else if (cur_i[IDX_HR][4:0] >= 5'h12) begin
          nxt_o[IDX_HR] = {2'b00, pm, 5'h01};
        end else begin
          t = bcd_inc({3'b000, cur_i[IDX_HR][4:0]});
          nxt_o[IDX_HR] = {2'b00, pm, t[4:0]};
        end
      end
    end

    if (c_hr) begin
      nxt_o[IDX_DOW] = (cur_i[IDX_DOW][2:0] >= 3'd6) ? 8'h00
                       : {5'b0, cur_i[IDX_DOW][2:0] + 3'd1};
      if (cur_i[IDX_DT] >= month_last(cur_i[IDX_MO], cur_i[IDX_YR])) begin
        nxt_o[IDX_DT] = 8'h01; c_dt = 1'b1;
      end else nxt_o[IDX_DT] = bcd_inc(cur_i[IDX_DT]);
    end

    if (c_dt) begin
      if (cur_i[IDX_MO] >= 8'h12) begin
        nxt_o[IDX_MO] = 8'h01; c_mo = 1'b1;
      end else nxt_o[IDX_MO] = bcd_inc(cur_i[IDX_MO]);
    end

    if (c_mo) begin
      if (cur_i[IDX_YR] >= 8'h99) begin
        nxt_o[IDX_YR] = 8'h00; c_yr = 1'b1;
      end else nxt_o[IDX_YR] = bcd_inc(cur_i[IDX_YR]);
    end

    if (c_yr && cur_i[IDX_CEN] == 8'h19) nxt_o[IDX_CEN] = 8'h20;
  end
endmodule

// File: rtl/cal_stage.sv
module cal_stage
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  cal_t              cur_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output cal_t              stage_o,
  output logic [NBYTES-1:0] mask_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    logic       dirty_q;
    logic       hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q  <= '0;
        dirty_q <= 1'b0;
      end else if (abort_i || commit_i) begin
        dirty_q <= 1'b0;
      end else if (hit) begin
        byte_q  <= wr_data_i;
        dirty_q <= 1'b1;
      end else if (load_i) begin
        byte_q  <= cur_i[g];
        dirty_q <= 1'b0;
      end
    end

    assign stage_o[g] = byte_q;
    assign mask_o[g]  = dirty_q;
  end

  // R11
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (mask_o == '0));
endmodule

// File: rtl/bcd_cal_timer.sv
module bcd_cal_timer
  import cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          snap_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          stage_load_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          commit_i,
  input  logic          abort_i,
  output logic          fail_o
);
  cal_t              time_q, snap_q, adv, stage, merged;
  logic [NBYTES-1:0] mask;
  logic              fail_q;
  logic              commit_go;

  cal_advance u_adv (.cur_i(time_q), .nxt_o(adv));

  cal_stage u_stage (
    .clk_i, .rst_ni,
    .load_i(stage_load_i), .cur_i(time_q),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .commit_i, .abort_i,
    .stage_o(stage), .mask_o(mask)
  );

  assign commit_go = commit_i && !abort_i && (|mask);

  for (genvar g = 0; g < NBYTES; g++) begin : g_merge
    assign merged[g] = mask[g] ? stage[g] : time_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= CAL_RESET;
      fail_q <= 1'b1;
    end else if (commit_go) begin
      time_q <= merged;
      fail_q <= 1'b0;
    end else if (tick_i && !fail_q) begin
      time_q <= adv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= CAL_RESET;
    else if (snap_i) snap_q <= time_q;
  end

  assign rd_data_o = snap_q[rd_addr_i];
  assign fail_o    = fail_q;

  // R2
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !commit_go) |=> $stable(time_q));
  // R2
  fail_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_go |=> !fail_o);
  // R9
  snap_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (snap_q == $past(time_q)));
  // R7
  century_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_go && time_q[IDX_CEN] == 8'h20) |=> (time_q[IDX_CEN] == 8'h20));
endmodule

// File: tb/bcd_cal_timer_tb.sv
module bcd_cal_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, snap_i = 1'b0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       stage_load_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       commit_i = 1'b0, abort_i = 1'b0;
  logic       fail_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    int         sel;   // 0..7 snapshot byte, 8 = fail flag
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];
  item_t it;
  logic [7:0] act;

  always #2 clk_i = ~clk_i;

  bcd_cal_timer u_dut (.*);

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      it  = q.pop_front();
      act = (it.sel == 8) ? {7'b0, fail_o} : rd_data_o;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input int sel, input logic [7:0] exp, input string req);
    item_t x;
    if (sel < 8) rd_addr_i = 3'(sel);
    x.sel = sel; x.exp = exp; x.req = req;
    q.push_back(x);
    @(negedge clk_i);
    step();
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; step(); tick_i = 1'b0; step();
    end
  endtask

  task automatic snap();
    snap_i = 1'b1; step(); snap_i = 1'b0;
  endtask

  task automatic load();
    stage_load_i = 1'b1; step(); stage_load_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; step(); wr_en_i = 1'b0;
  endtask

  task automatic commit();
    commit_i = 1'b1; step(); commit_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] c, dw, y, mo, d, h, m, s);
    load();
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, d);
    wr(3'd4, mo); wr(3'd5, y); wr(3'd6, dw); wr(3'd7, c);
    commit();
  endtask

  task automatic chk_all(input logic [7:0] c, dw, y, mo, d, h, m, s, input string req);
    snap();
    chk(0, s, req); chk(1, m, req); chk(2, h, req); chk(3, d, req);
    chk(4, mo, req); chk(5, y, req); chk(6, dw, req); chk(7, c, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();

    // R1 reset state
    chk(8, 8'h01, "R1");
    chk_all(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00, "R1");

    // R2 ticks ignored while failed, empty commit does nothing
    tick(3);
    snap(); chk(0, 8'h00, "R2");
    load(); commit();
    chk(8, 8'h01, "R2");
    tick(1);
    snap(); chk(0, 8'h00, "R2");

    // R2 one byte write clears flag, R3 sec/min carry
    load(); wr(3'd0, 8'h58); commit();
    chk(8, 8'h00, "R2");
    tick(1); snap(); chk(0, 8'h59, "R3");
    tick(1); snap(); chk(0, 8'h00, "R3"); chk(1, 8'h01, "R3");

    // R4 R7 R8 full rollover, century 19 -> 20
    set_time(8'h19, 8'h06, 8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59);
    tick(1);
    chk_all(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00, "R7");

    // R7 century stays at 20
    set_time(8'h20, 8'h02, 8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59);
    tick(1); snap(); chk(5, 8'h00, "R7"); chk(7, 8'h20, "R7"); chk(6, 8'h03, "R8");

    // R6 leap and month lengths
    set_time(8'h20, 8'h03, 8'h24, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59);
    tick(1); snap(); chk(3, 8'h29, "R6"); chk(4, 8'h02, "R6"); chk(6, 8'h04, "R8");
    chk(2, 8'h80, "R4");
    set_time(8'h20, 8'h03, 8'h24, 8'h02, 8'h29, 8'hA3, 8'h59, 8'h59);
    tick(1); snap(); chk(3, 8'h01, "R6"); chk(4, 8'h03, "R6");
    set_time(8'h20, 8'h03, 8'h23, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59);
    tick(1); snap(); chk(3, 8'h01, "R6"); chk(4, 8'h03, "R6");
    set_time(8'h20, 8'h03, 8'h00, 8'h02, 8'h28, 8'hA3, 8'h59, 8'h59);
    tick(1); snap(); chk(3, 8'h29, "R6");
    set_time(8'h20, 8'h03, 8'h23, 8'h04, 8'h30, 8'hA3, 8'h59, 8'h59);
    tick(1); snap(); chk(3, 8'h01, "R6"); chk(4, 8'h05, "R6");
    set_time(8'h20, 8'h03, 8'h23, 8'h01, 8'h30, 8'hA3, 8'h59, 8'h59);
    tick(1); snap(); chk(3, 8'h31, "R6");

    // R4 mid-day 24h step 09 -> 10
    set_time(8'h20, 8'h03, 8'h23, 8'h01, 8'h10, 8'h89, 8'h59, 8'h59);
    tick(1); snap(); chk(2, 8'h90, "R4"); chk(3, 8'h10, "R4");

    // R5 12-hour sequence
    set_time(8'h20, 8'h03, 8'h24, 8'h05, 8'h10, 8'h11, 8'h59, 8'h59);
    tick(1); snap(); chk(2, 8'h32, "R5"); chk(3, 8'h10, "R5");
    set_time(8'h20, 8'h03, 8'h24, 8'h05, 8'h10, 8'h32, 8'h59, 8'h59);
    tick(1); snap(); chk(2, 8'h21, "R5");
    set_time(8'h20, 8'h03, 8'h24, 8'h05, 8'h10, 8'h31, 8'h59, 8'h59);
    tick(1); snap(); chk(2, 8'h12, "R5"); chk(3, 8'h11, "R5"); chk(6, 8'h04, "R8");
    set_time(8'h20, 8'h03, 8'h24, 8'h05, 8'h10, 8'h12, 8'h59, 8'h59);
    tick(1); snap(); chk(2, 8'h01, "R5"); chk(3, 8'h10, "R5");

    // R11 abort discards, abort beats commit
    set_time(8'h20, 8'h01, 8'h24, 8'h05, 8'h10, 8'h88, 8'h05, 8'h10);
    load(); wr(3'd0, 8'h33);
    abort_i = 1'b1; step(); abort_i = 1'b0;
    commit();
    snap(); chk(0, 8'h10, "R11");
    load(); wr(3'd0, 8'h44);
    abort_i = 1'b1; commit_i = 1'b1; step(); abort_i = 1'b0; commit_i = 1'b0;
    snap(); chk(0, 8'h10, "R11");

    // R10 single byte write leaves running bytes alone
    load(); tick(2); wr(3'd1, 8'h40); commit();
    snap(); chk(0, 8'h12, "R10"); chk(1, 8'h40, "R10"); chk(2, 8'h88, "R10");

    // R9 snapshot holds while counting continues
    tick(2); chk(0, 8'h12, "R9");
    snap(); chk(0, 8'h14, "R9");
    tick_i = 1'b1; snap_i = 1'b1; step(); tick_i = 1'b0; snap_i = 1'b0;
    chk(0, 8'h14, "R9");
    snap(); chk(0, 8'h15, "R9");

    // R12 tick coincident with commit is dropped
    load(); wr(3'd0, 8'h20);
    commit_i = 1'b1; tick_i = 1'b1; step(); commit_i = 1'b0; tick_i = 1'b0;
    snap(); chk(0, 8'h20, "R12");
    tick(1); snap(); chk(0, 8'h21, "R12");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule